// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a two-wire serial protocol engine and a 64K-byte storage array that is organised as 512 rows of 128 bytes. It owns the 16-bit internal address counter. Incoming data bytes are gathered into a 128-byte staging buffer, and a per-byte mask records which offsets were actually received. While bytes are gathered, only the in-row offset advances, so the row never changes. When the protocol engine signals the stop condition, the received bytes are copied into the array through a simple write port. A fixed self-timed busy window follows the copy. During the copy and the busy window, every strobe from the protocol engine is ignored.

Reads use the same counter. Each read-advance strobe captures the array byte at the counter into a data register and then steps the counter across the whole 64K space. The step from the top address goes to zero. A write-protect input stops any commit from reaching the array. A stop that arrives with no bytes gathered is a dummy write. It only leaves the loaded address in the counter.

Top module: `page_commit_ctrl`

## Requirements
- R1: After reset, `rd_addr` is 0, `rd_data` is 0, `busy` is 0 and `arr_we` is 0.
- R2: An accepted `addr_load` puts `addr_in` into the counter. The new value is visible on `rd_addr` in the next cycle. The load also discards any bytes gathered before it, so they are never committed.
- R3: An accepted `wr_byte_valid` stores `wr_byte` at the offset given by counter bits [6:0]. It then increments only bits [6:0], and bits [15:7] stay unchanged. Offset 0x7F is followed by offset 0x00 of the same row.
- R4: When more than 128 bytes arrive, a later byte replaces the earlier byte at the same offset. Each offset is written to the array at most once, and it carries the last value received for it.
- R5: A commit writes only the offsets that received a byte. The write address is {row, offset}, and the offsets are visited in ascending order. The row is the value of counter bits [15:7] when the first byte arrived.
- R6: The array is written only after an accepted `stop_commit`. `busy` rises in the cycle after the stop and stays high for exactly 128 + BUSY_CYCLES cycles. `arr_we` is high only while `busy` is high.
- R7: When `wp` is 1 at the stop, the gathered bytes are discarded, `busy` does not rise and no array write happens. While `wp` is 1, `arr_we` stays 0.
- R8: A stop with no gathered bytes writes nothing, does not raise `busy` and leaves the counter unchanged.
- R9: An accepted `rd_adv` loads `rd_data` with the array byte at `rd_addr` (that is, `arr_rdata`) and increments the counter by one. After a write sequence, the counter holds the address after the last byte written, within the same row.
- R10: On reads, the counter steps from 0xFFFF to 0x0000.
- R11: While `busy` is 1, `addr_load`, `wr_byte_valid`, `rd_adv` and `stop_commit` have no effect on the counter, the staging buffer or `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wp | input | 1 | Write protect; 1 blocks every array write |
| addr_load | input | 1 | Strobe to load the word address |
| addr_in | input | 16 | Word address to load |
| wr_byte_valid | input | 1 | Strobe that a data byte has been received |
| wr_byte | input | 8 | Received data byte |
| stop_commit | input | 1 | Stop condition; commits the gathered bytes |
| rd_adv | input | 1 | Read strobe: capture byte, advance counter |
| arr_rdata | input | 8 | Array read data at `rd_addr` |
| rd_addr | output | 16 | Current counter value and array read address |
| rd_data | output | 8 | Last byte captured by a read |
| busy | output | 1 | Commit or self-timed window in progress |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | 16 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The assertions check four things on every cycle. `busy` never rises without a stop. A protected stop or an empty stop never raises `busy`. `arr_we` is high only inside the busy window. The counter and the read register stay frozen while `busy` is high. The counter assertions also check that a byte write never changes the row and that a read from 0xFFFF goes to zero. Some behaviours can only be shown by the bench's scenarios, which compare every array write against a queue of expected writes. These are the write order and the write values after an in-row wrap and after an overrun of more than 128 bytes. They also include the loss of bytes gathered before a new address load, the exact length of the busy window, and read data that matches what was committed.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_SWEEP = 2'd1,
        SEQ_WAIT  = 2'd2
    } seq_state_e;
endpackage

// File: rtl/pcc_addr_ctr.sv
module pcc_addr_ctr #(
    parameter int ADDR_W = 16,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_val,
    input  logic              wr_step,
    input  logic              rd_step,
    output logic [ADDR_W-1:0] addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } ctr_t;

    ctr_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.addr = load_val;
        end else if (wr_step) begin
            s_d.addr[PAGE_W-1:0] = s_q.addr[PAGE_W-1:0] + PAGE_W'(1);
        end else if (rd_step) begin
            s_d.addr = s_q.addr + ADDR_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign addr_o = s_q.addr;

    AST_WRITE_KEEPS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_step && !load) |=> (addr_o[ADDR_W-1:PAGE_W] == $past(addr_o[ADDR_W-1:PAGE_W]))); // R3

    AST_READ_WRAPS_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_step && !load && !wr_step && (&addr_o)) |=> (addr_o == '0)); // R10
endmodule

// File: rtl/pcc_page_buf.sv
module pcc_page_buf #(
    parameter int DATA_W = 8,
    parameter int PAGE_W = 7,
    parameter int ROW_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              wr_en,
    input  logic [PAGE_W-1:0] wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ROW_W-1:0]  row_in,
    input  logic [PAGE_W-1:0] rd_idx,
    output logic [DATA_W-1:0] byte_o,
    output logic              valid_o,
    output logic              any_valid_o,
    output logic [ROW_W-1:0]  row_o
);
    localparam int SLOTS = 1 << PAGE_W;

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] data;
        logic [SLOTS-1:0]             valid;
        logic [ROW_W-1:0]             row;
    } buf_t;

    buf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear) begin
            s_d.valid = '0;
        end else if (wr_en) begin
            if (s_q.valid == '0) s_d.row = row_in;
            s_d.data[wr_idx]  = wr_data;
            s_d.valid[wr_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign byte_o      = s_q.data[rd_idx];
    assign valid_o     = s_q.valid[rd_idx];
    assign any_valid_o = |s_q.valid;
    assign row_o       = s_q.row;

    AST_CLEAR_EMPTIES_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> !any_valid_o); // R2
endmodule

// File: rtl/pcc_commit_seq.sv
module pcc_commit_seq
    import pcc_pkg::*;
#(
    parameter int PAGE_W      = 7,
    parameter int BUSY_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              go,
    output logic              busy_o,
    output logic              sweep_o,
    output logic [PAGE_W-1:0] idx_o,
    output logic              done_o
);
    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [PAGE_W-1:0] LAST_IDX = {PAGE_W{1'b1}};

    typedef struct packed {
        seq_state_e        state;
        logic [PAGE_W-1:0] idx;
        logic [CNT_W-1:0]  cnt;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        done_o = 1'b0;
        case (s_q.state)
            SEQ_IDLE: begin
                if (start && go) begin
                    s_d.state = SEQ_SWEEP;
                    s_d.idx   = '0;
                end
            end
            SEQ_SWEEP: begin
                s_d.idx = s_q.idx + PAGE_W'(1);
                if (s_q.idx == LAST_IDX) begin
                    done_o    = 1'b1;
                    s_d.state = SEQ_WAIT;
                    s_d.cnt   = CNT_W'(BUSY_CYCLES - 1);
                end
            end
            SEQ_WAIT: begin
                if (s_q.cnt == '0) s_d.state = SEQ_IDLE;
                else               s_d.cnt   = s_q.cnt - CNT_W'(1);
            end
            default: s_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{state: SEQ_IDLE, idx: '0, cnt: '0};
        else        s_q <= s_d;
    end

    assign busy_o  = (s_q.state != SEQ_IDLE);
    assign sweep_o = (s_q.state == SEQ_SWEEP);
    assign idx_o   = s_q.idx;
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl #(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int PAGE_W      = 7,
    parameter int BUSY_CYCLES = 500000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wp,
    input  logic              addr_load,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              wr_byte_valid,
    input  logic [DATA_W-1:0] wr_byte,
    input  logic              stop_commit,
    input  logic              rd_adv,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [DATA_W-1:0] arr_wdata
);
    localparam int ROW_W = ADDR_W - PAGE_W;

    logic              ld_acc, wr_acc, rd_acc, stop_acc, go;
    logic              sweep, done, any_valid, slot_valid, buf_clear;
    logic [PAGE_W-1:0] sweep_idx;
    logic [ROW_W-1:0]  row;
    logic [DATA_W-1:0] slot_byte;

    assign ld_acc   = addr_load && !busy;
    assign wr_acc   = wr_byte_valid && !busy && !addr_load;
    assign rd_acc   = rd_adv && !busy && !addr_load && !wr_byte_valid;
    assign stop_acc = stop_commit && !busy;
    assign go       = any_valid && !wp;
    assign buf_clear = ld_acc || (stop_acc && !go) || done;

    pcc_addr_ctr #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .load(ld_acc), .load_val(addr_in),
        .wr_step(wr_acc), .rd_step(rd_acc), .addr_o(rd_addr)
    );

    pcc_page_buf #(.DATA_W(DATA_W), .PAGE_W(PAGE_W), .ROW_W(ROW_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear), .wr_en(wr_acc),
        .wr_idx(rd_addr[PAGE_W-1:0]), .wr_data(wr_byte),
        .row_in(rd_addr[ADDR_W-1:PAGE_W]), .rd_idx(sweep_idx),
        .byte_o(slot_byte), .valid_o(slot_valid), .any_valid_o(any_valid),
        .row_o(row)
    );

    pcc_commit_seq #(.PAGE_W(PAGE_W), .BUSY_CYCLES(BUSY_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(stop_acc), .go(go),
        .busy_o(busy), .sweep_o(sweep), .idx_o(sweep_idx), .done_o(done)
    );

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
    } rd_t;

    rd_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (rd_acc) r_d.rdata = arr_rdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rd_data   = r_q.rdata;
    assign arr_we    = sweep && slot_valid && !wp;
    assign arr_waddr = {row, sweep_idx};
    assign arr_wdata = slot_byte;

    AST_COMMIT_NEEDS_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !stop_commit) |=> !busy); // R6

    AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R6

    AST_NO_COMMIT_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_commit && !busy && wp) |=> !busy); // R7

    AST_NO_COMMIT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_commit && !busy && !any_valid) |=> !busy); // R8

    AST_FROZEN_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> ($stable(rd_data) && (rd_addr == $past(rd_addr)))); // R11
endmodule

// File: tb/page_commit_ctrl_test.sv
module page_commit_ctrl_test;
    localparam int BC = 40;
    localparam int BUSY_LEN = 128 + BC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wp = 1'b0;
    logic        addr_load = 1'b0;
    logic [15:0] addr_in = '0;
    logic        wr_byte_valid = 1'b0;
    logic [7:0]  wr_byte = '0;
    logic        stop_commit = 1'b0;
    logic        rd_adv = 1'b0;
    logic [7:0]  arr_rdata;
    logic [15:0] rd_addr, arr_waddr;
    logic [7:0]  rd_data, arr_wdata;
    logic        busy, arr_we;

    int n_checks = 0;
    int n_fail   = 0;

    logic [7:0]  mem     [0:4095];
    logic [7:0]  ref_mem [0:4095];
    logic [23:0] exp_q [$];

    logic [7:0]  sb_data  [0:127];
    logic        sb_valid [0:127];
    logic [8:0]  sb_row;
    logic        sb_any;
    logic [15:0] exp_addr;

    always #5 clk = ~clk;

    page_commit_ctrl #(.BUSY_CYCLES(BC)) uut (
        .clk(clk), .rst_n(rst_n), .wp(wp), .addr_load(addr_load), .addr_in(addr_in),
        .wr_byte_valid(wr_byte_valid), .wr_byte(wr_byte), .stop_commit(stop_commit),
        .rd_adv(rd_adv), .arr_rdata(arr_rdata), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction

    // array model (aliased to 12 address bits)
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4096; i++) mem[i] <= pat(i);
        end else if (arr_we) begin
            mem[arr_waddr[11:0]] <= arr_wdata;
        end
    end
    always_comb arr_rdata = mem[rd_addr[11:0]];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && arr_we) begin
            if (exp_q.size() == 0) begin
                chk("R6 unexpected array write", {8'h0, arr_waddr, arr_wdata}, 32'hFFFFFFFF);
            end else begin
                logic [23:0] e;
                e = exp_q.pop_front();
                chk("R5 array write addr/data", {8'h0, arr_waddr, arr_wdata}, {8'h0, e});
            end
        end
    end

    task automatic do_load(input logic [15:0] a);
        addr_load = 1'b1; addr_in = a;
        @(negedge clk);
        addr_load = 1'b0;
        exp_addr = a;
        for (int i = 0; i < 128; i++) sb_valid[i] = 1'b0;
        sb_any = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] d);
        wr_byte_valid = 1'b1; wr_byte = d;
        @(negedge clk);
        wr_byte_valid = 1'b0;
        if (!sb_any) sb_row = exp_addr[15:7];
        sb_data[exp_addr[6:0]]  = d;
        sb_valid[exp_addr[6:0]] = 1'b1;
        sb_any = 1'b1;
        exp_addr[6:0] = exp_addr[6:0] + 7'd1;
    endtask

    task automatic do_stop(input string req);
        logic commit;
        int n;
        commit = sb_any && !wp;
        stop_commit = 1'b1;
        if (commit) begin
            for (int i = 0; i < 128; i++) begin
                if (sb_valid[i]) begin
                    exp_q.push_back({sb_row, 7'(i), sb_data[i]});
                    ref_mem[{sb_row[4:0], 7'(i)}] = sb_data[i];
                end
            end
        end
        for (int i = 0; i < 128; i++) sb_valid[i] = 1'b0;
        sb_any = 1'b0;
        @(negedge clk);
        stop_commit = 1'b0;
        if (commit) begin
            n = 0;
            while (busy) begin n++; @(negedge clk); end
            chk({req, " R6 busy length"}, n, BUSY_LEN);
        end else begin
            chk({req, " no busy"}, {31'd0, busy}, 0);
        end
        chk({req, " scoreboard drained"}, exp_q.size(), 0);
    endtask

    task automatic do_read(input string req);
        rd_adv = 1'b1;
        @(negedge clk);
        rd_adv = 1'b0;
        chk({req, " read data"}, rd_data, ref_mem[exp_addr[11:0]]);
        exp_addr = exp_addr + 16'd1;
        chk({req, " counter after read"}, rd_addr, exp_addr);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) ref_mem[i] = pat(i);
        for (int i = 0; i < 128; i++) sb_valid[i] = 1'b0;
        sb_any = 1'b0; sb_row = '0; exp_addr = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 rd_addr", rd_addr, 0);
        chk("R1 rd_data", rd_data, 0);
        chk("R1 busy", {31'd0, busy}, 0);
        chk("R1 arr_we", {31'd0, arr_we}, 0);

        // R2 load, R3 in-row increment, R5/R6 partial commit
        do_load(16'h1234);
        chk("R2 loaded address", rd_addr, 16'h1234);
        do_byte(8'hA1); do_byte(8'hA2); do_byte(8'hA3);
        chk("R3 counter after bytes", rd_addr, 16'h1237);
        chk("R6 no busy before stop", {31'd0, busy}, 0);
        do_stop("R5 partial");
        chk("R9 counter is last+1", rd_addr, 16'h1237);
        do_load(16'h1234);
        do_read("R9 seq0"); do_read("R9 seq1"); do_read("R9 seq2");

        // R3 wrap inside row, R5 ascending order
        do_load(16'h2A7E);
        do_byte(8'h11); do_byte(8'h22); do_byte(8'h33); do_byte(8'h44);
        chk("R3 wrap keeps row", rd_addr, 16'h2A02);
        do_stop("R3 wrap");

        // R4 overrun of 130 bytes
        do_load(16'h0500);
        for (int i = 0; i < 130; i++) do_byte(8'(i + 8'h40));
        chk("R4 counter after overrun", rd_addr, 16'h0502);
        do_stop("R4 overrun");
        do_load(16'h0500);
        do_read("R4 offset0 newest"); do_read("R4 offset1 newest"); do_read("R4 offset2");

        // R2 new address drops earlier bytes
        do_load(16'h0600); do_byte(8'h5A);
        do_load(16'h0700); do_byte(8'hC3);
        do_stop("R2 reload");
        do_load(16'h0600);
        do_read("R2 dropped byte untouched");

        // R7 write protect
        wp = 1'b1;
        do_load(16'h0300); do_byte(8'hEE); do_byte(8'hEF);
        do_stop("R7 protected");
        wp = 1'b0;
        do_load(16'h0300);
        do_read("R7 array unchanged");
        chk("R7 stop after protect is empty", {31'd0, busy}, 0);
        do_stop("R7 buffer discarded");

        // R8 dummy write then random read
        do_load(16'h0ABC);
        do_stop("R8 dummy");
        chk("R8 counter kept", rd_addr, 16'h0ABC);
        do_read("R9 random read");

        // R10 rollover
        do_load(16'hFFFE);
        do_read("R10 FFFE"); do_read("R10 FFFF"); do_read("R10 0000");
        chk("R10 counter wrapped", rd_addr, 16'h0001);

        // R11 strobes ignored while busy
        do_load(16'h0800); do_byte(8'h77);
        stop_commit = 1'b1;
        exp_q.push_back({16'h0800, 8'h77});
        ref_mem[12'h800] = 8'h77;
        for (int i = 0; i < 128; i++) sb_valid[i] = 1'b0;
        sb_any = 1'b0;
        @(negedge clk);
        stop_commit = 1'b0;
        chk("R11 busy raised", {31'd0, busy}, 1);
        begin
            logic [7:0] held;
            held = rd_data;
            addr_load = 1'b1; addr_in = 16'h4444; wr_byte_valid = 1'b1;
            wr_byte = 8'h99; rd_adv = 1'b1; stop_commit = 1'b1;
            @(negedge clk);
            addr_load = 1'b0; wr_byte_valid = 1'b0; rd_adv = 1'b0; stop_commit = 1'b0;
            chk("R11 counter frozen", rd_addr, 16'h0801);
            chk("R11 rd_data frozen", rd_data, held);
        end
        while (busy) @(negedge clk);
        chk("R11 scoreboard drained", exp_q.size(), 0);
        do_stop("R11 ignored byte not buffered");

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule